// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Receiver

This block turns the two lines of a 1.5 Mb/s differential bus into stored bytes. It first passes both lines through a two-flop synchroniser. It then waits for the bus to leave its idle level and looks for the opening bit pattern. Each following bit period is sampled near its centre. The level sequence is decoded as NRZI, and the extra bits the transmitter inserts after long runs of ones are removed. Bytes are built least significant bit first. Each complete byte is presented on a write strobe together with a buffer address that counts up from zero in every packet.

A packet ends when both lines are held low (SE0). The receiver then pulses `pkt_done` with the number of bytes it stored. The first bit position after every stored byte is not tested for SE0, so a stray trailing bit from an upstream repeater does not cut the packet short. Two conditions end reception without `pkt_done`. A packet longer than the buffer raises `ovf_err`. A start pattern that never completes raises `sync_err`.

The controller has six states:
- `ST_WAIT_J`: waits for the idle level J, then moves to `ST_IDLE`.
- `ST_IDLE`: waits for K, seeds the bit clock, then moves to `ST_SYNC_CHK`.
- `ST_SYNC_CHK`: samples the next bit centre. K moves it to `ST_DATA`, J moves it to `ST_HUNT`.
- `ST_HUNT`: a K moves it back to `ST_SYNC_CHK`. A timeout moves it to `ST_IDLE` with `sync_err`.
- `ST_DATA`: an SE0 at a checked position moves it to `ST_WAIT_J` with `pkt_done`. A byte that does not fit moves it to `ST_DRAIN` with `ovf_err`.
- `ST_DRAIN`: waits for SE0, then moves to `ST_WAIT_J`.

Top module: `ls_rx_core`

## Requirements
- R1: After reset, `wr_en`, `pkt_done`, `sync_err` and `ovf_err` are low and `pkt_len` is 0.
- R2: A packet is recognised when a J-to-K change is followed by a bit period sampled as K at its centre. A period sampled as J instead sends the receiver back to looking for the next K. The opening pattern on the lines is K,J,K,J,K,J,K,K.
- R3: Each data bit is decoded as 1 when the level matches the previous bit period and as 0 when it differs.
- R4: Bit 0 of each byte is the first bit received. The bytes of a packet are written with `wr_en` at `wr_addr` 0,1,2,… in order, and writes are never on adjacent cycles.
- R5: After six decoded 1s in a row (the final opening-pattern bit counts as a 1), the next bit period is dropped and does not enter any byte.
- R6: SE0 sampled at bit positions 1 to 7 ends the packet. It gives one `pkt_done` pulse with `pkt_len` equal to the number of bytes written, and any partial byte is discarded.
- R7: SE0 sampled at bit position 0, with no stuffed bit due, is decoded as an ordinary bit. A single extra bit after the last byte therefore does not change the result.
- R8: SE0 sampled where a stuffed bit is due ends the packet at once.
- R9: Once `BUF_DEPTH` bytes have been written, the next complete byte is not written. It pulses `ovf_err` without `pkt_done`, the rest of the packet is ignored until SE0, and the next packet starts again at address 0.
- R10: If J persists for `HUNT_LIMIT` clocks while the receiver is looking for the next K, it pulses `sync_err` and writes nothing.
- R11: Every level change in a packet realigns sampling to half a bit period later, so bit periods that are longer than nominal still decode correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, `CLKS_PER_BIT` per bit period |
| rst_n | input | 1 | Active-low reset |
| usb_dp | input | 1 | Positive data line, asynchronous |
| usb_dm | input | 1 | Negative data line, asynchronous |
| wr_en | output | 1 | One-cycle byte write strobe |
| wr_addr | output | AW | Buffer address of the byte |
| wr_data | output | 8 | Received byte |
| pkt_done | output | 1 | One-cycle end-of-packet pulse |
| pkt_len | output | LW | Bytes stored in the finished packet |
| sync_err | output | 1 | One-cycle pulse when the opening pattern fails |
| ovf_err | output | 1 | One-cycle pulse when the buffer overflows |

## Verification
The bench builds the receiver with `CLKS_PER_BIT` = 10, `HUNT_LIMIT` = 10 and `BUF_DEPTH` = 4. The small buffer lets a five-byte packet reach the overflow path and the recovery from it, with the packets kept short. The standard bit rate puts each SE0 case on an exact bit position: mid-byte, at position 0 and on a due stuffed bit. One packet is also sent with 11-clock bit periods. With that drift, decoding is only correct if the per-transition realignment works.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_WAIT_J,
        ST_IDLE,
        ST_SYNC_CHK,
        ST_HUNT,
        ST_DATA,
        ST_DRAIN
    } rx_state_t;
endpackage

// File: rtl/lsrx_sync2.sv
module lsrx_sync2 #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta   <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta   <= d_async;
            q_sync <= meta;
        end
    end
endmodule

// File: rtl/lsrx_bit_clock.sv
// Phase counter: tick marks a bit centre. seed aims at the centre of the
// period after the current one; realign aims at the centre of the current one.
module lsrx_bit_clock #(
    parameter int CLKS_PER_BIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed,
    input  logic realign,
    output logic tick
);
    localparam int HALF   = CLKS_PER_BIT / 2;
    localparam int SEED_V = CLKS_PER_BIT + HALF - 1;
    localparam int CW     = $clog2(SEED_V + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= CW'(CLKS_PER_BIT - 1);
        else if (seed)
            cnt <= CW'(SEED_V);
        else if (realign)
            cnt <= CW'(HALF - 1);
        else if (cnt == '0)
            cnt <= CW'(CLKS_PER_BIT - 1);
        else
            cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0) && !realign;
endmodule

// File: rtl/ls_rx_core.sv
module ls_rx_core
    import lsrx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 10,
    parameter int BUF_DEPTH    = 16,
    parameter int HUNT_LIMIT   = 10,
    localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
    localparam int LW = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_dp,
    input  logic              usb_dm,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              pkt_done,
    output logic [LW-1:0]     pkt_len,
    output logic              sync_err,
    output logic              ovf_err
);
    localparam int          HW        = $clog2(HUNT_LIMIT + 1);
    localparam logic [LW-1:0] DEPTH_L = LW'(BUF_DEPTH);
    localparam logic [2:0]  STUFF_RUN = 3'd6;

    logic [1:0] line_s;
    logic       dp_s, dm_s, dm_d;
    logic       line_j, line_k, line_se0, edge_seen;
    logic       tick, seed, realign, bit_v;

    rx_state_t         state, state_n;
    logic [2:0]        ones, ones_n, bidx, bidx_n;
    logic [BYTE_W-1:0] acc, acc_n;
    logic              prev_dm, prev_n;
    logic [LW-1:0]     room, room_n;
    logic [HW-1:0]     hcnt, hcnt_n;
    logic              wr_en_n, done_n, serr_n, oerr_n;
    logic [AW-1:0]     wr_addr_n;
    logic [BYTE_W-1:0] wr_data_n;
    logic [LW-1:0]     len_n;

    lsrx_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({usb_dp, usb_dm}),
        .q_sync  (line_s)
    );

    assign dp_s      = line_s[1];
    assign dm_s      = line_s[0];
    assign line_j    = !dp_s && dm_s;
    assign line_k    = dp_s && !dm_s;
    assign line_se0  = !dp_s && !dm_s;
    assign edge_seen = dm_s != dm_d;
    assign realign   = (state == ST_DATA) && edge_seen;
    assign bit_v     = (dm_s == prev_dm);

    lsrx_bit_clock #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_bclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed    (seed),
        .realign (realign),
        .tick    (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_J;
        else        state <= state_n;
    end

    // next state and next datapath values
    always_comb begin
        state_n   = state;
        ones_n    = ones;
        bidx_n    = bidx;
        acc_n     = acc;
        prev_n    = prev_dm;
        room_n    = room;
        hcnt_n    = hcnt;
        wr_en_n   = 1'b0;
        wr_addr_n = wr_addr;
        wr_data_n = wr_data;
        done_n    = 1'b0;
        len_n     = pkt_len;
        serr_n    = 1'b0;
        oerr_n    = 1'b0;
        seed      = 1'b0;
        unique case (state)
            ST_WAIT_J: if (line_j) state_n = ST_IDLE;
            ST_IDLE: if (line_k) begin
                seed    = 1'b1;
                state_n = ST_SYNC_CHK;
            end
            ST_SYNC_CHK: if (tick) begin
                if (line_k) begin
                    state_n = ST_DATA;
                    ones_n  = 3'd1;
                    bidx_n  = 3'd0;
                    prev_n  = 1'b0;
                    room_n  = DEPTH_L;
                end else begin
                    state_n = ST_HUNT;
                    hcnt_n  = '0;
                end
            end
            ST_HUNT: begin
                if (line_k) begin
                    seed    = 1'b1;
                    state_n = ST_SYNC_CHK;
                end else if (hcnt == HW'(HUNT_LIMIT - 1)) begin
                    serr_n  = 1'b1;
                    state_n = ST_IDLE;
                end else begin
                    hcnt_n = hcnt + 1'b1;
                end
            end
            ST_DATA: if (tick) begin
                if (line_se0 && (bidx != 3'd0 || ones == STUFF_RUN)) begin
                    done_n  = 1'b1;
                    len_n   = DEPTH_L - room;
                    state_n = ST_WAIT_J;
                end else begin
                    prev_n = dm_s;
                    if (ones == STUFF_RUN) begin
                        ones_n = 3'd0;
                    end else begin
                        ones_n      = bit_v ? ones + 3'd1 : 3'd0;
                        acc_n[bidx] = bit_v;
                        bidx_n      = bidx + 3'd1;
                        if (bidx == 3'd7) begin
                            if (room == '0) begin
                                oerr_n  = 1'b1;
                                state_n = ST_DRAIN;
                            end else begin
                                wr_en_n   = 1'b1;
                                wr_data_n = acc_n;
                                wr_addr_n = AW'(DEPTH_L - room);
                                room_n    = room - 1'b1;
                            end
                        end
                    end
                end
            end
            ST_DRAIN: if (line_se0) state_n = ST_WAIT_J;
            default: state_n = ST_WAIT_J;
        endcase
    end

    // registered datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dm_d     <= 1'b1;
            ones     <= '0;
            bidx     <= '0;
            acc      <= '0;
            prev_dm  <= 1'b1;
            room     <= DEPTH_L;
            hcnt     <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            pkt_done <= 1'b0;
            pkt_len  <= '0;
            sync_err <= 1'b0;
            ovf_err  <= 1'b0;
        end else begin
            dm_d     <= dm_s;
            ones     <= ones_n;
            bidx     <= bidx_n;
            acc      <= acc_n;
            prev_dm  <= prev_n;
            room     <= room_n;
            hcnt     <= hcnt_n;
            wr_en    <= wr_en_n;
            wr_addr  <= wr_addr_n;
            wr_data  <= wr_data_n;
            pkt_done <= done_n;
            pkt_len  <= len_n;
            sync_err <= serr_n;
            ovf_err  <= oerr_n;
        end
    end
endmodule

// File: rtl/ls_rx_core_checker.sv
module ls_rx_core_checker #(
    parameter int BUF_DEPTH = 16,
    parameter int AW = 4,
    parameter int LW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          pkt_done,
    input logic [LW-1:0] pkt_len,
    input logic          sync_err,
    input logic          ovf_err
);
    logic [LW-1:0] nwr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 nwr <= '0;
        else if (pkt_done || ovf_err) nwr <= '0;
        else if (wr_en)             nwr <= nwr + 1'b1;
    end

    p_addr_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (LW'(wr_addr) == nwr));
    p_wr_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    p_len_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len == nwr));
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (nwr < LW'(BUF_DEPTH)));
    p_ovf_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> (nwr == LW'(BUF_DEPTH)));
    p_excl_events_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, pkt_done, sync_err, ovf_err}));
    p_serr_nodata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> (nwr == '0));
endmodule

bind ls_rx_core ls_rx_core_checker #(.BUF_DEPTH(BUF_DEPTH), .AW(AW), .LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .pkt_done (pkt_done),
    .pkt_len  (pkt_len),
    .sync_err (sync_err),
    .ovf_err  (ovf_err)
);

// File: tb/ls_rx_core_tb.sv
`timescale 1ns/1ps
module ls_rx_core_tb_top;
    localparam int CPB = 10, DEPTH = 4, HLIM = 10;
    localparam int AW = 2, LW = 3;
    localparam int SYM_SE0 = 0, SYM_J = 1, SYM_K = 2;

    logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b1;
    logic wr_en, pkt_done, sync_err, ovf_err;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [LW-1:0] pkt_len;

    always #2 clk = ~clk;

    ls_rx_core #(.CLKS_PER_BIT(CPB), .BUF_DEPTH(DEPTH), .HUNT_LIMIT(HLIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .usb_dp(dp), .usb_dm(dm),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pkt_done(pkt_done), .pkt_len(pkt_len),
        .sync_err(sync_err), .ovf_err(ovf_err)
    );

    int checks = 0, fails = 0;
    int sym_q[$];
    int exp_wr[$];
    int exp_len[$];
    int exp_serr = 0, exp_oerr = 0;
    int lvl = SYM_J, ones = 0;
    bit no_stuff = 0, mon_on = 0, finished = 0;
    string tag = "R1";

    task automatic fail(string req, int act, int exp);
        fails++;
        $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    endtask

    // behavioural line encoder
    function automatic void put_sym(int s);
        sym_q.push_back(s);
    endfunction
    function automatic int flip(int s);
        return (s == SYM_J) ? SYM_K : SYM_J;
    endfunction
    function automatic void add_idle(int n);
        for (int i = 0; i < n; i++) put_sym(SYM_J);
        lvl = SYM_J;
    endfunction
    function automatic void add_sync();
        put_sym(SYM_K); put_sym(SYM_J); put_sym(SYM_K); put_sym(SYM_J);
        put_sym(SYM_K); put_sym(SYM_J); put_sym(SYM_K); put_sym(SYM_K);
        lvl = SYM_K; ones = 1;
    endfunction
    function automatic void add_bit(int b);
        if (b == 0) begin lvl = flip(lvl); ones = 0; end
        else ones++;
        put_sym(lvl);
        if (ones == 6) begin
            if (!no_stuff) begin lvl = flip(lvl); put_sym(lvl); end
            ones = 0;
        end
    endfunction
    function automatic void add_byte(int v);
        for (int i = 0; i < 8; i++) add_bit((v >> i) & 1);
    endfunction
    function automatic void add_eop();
        put_sym(SYM_SE0); put_sym(SYM_SE0);
        add_idle(4);
    endfunction
    function automatic void expect_pkt(int n, int v0, int v1, int v2);
        int vals[3];
        vals[0] = v0; vals[1] = v1; vals[2] = v2;
        for (int i = 0; i < n; i++) exp_wr.push_back(i * 256 + vals[i]);
        exp_len.push_back(n);
    endfunction

    task automatic play(int cpb);
        while (sym_q.size() > 0) begin
            int s;
            s = sym_q.pop_front();
            @(negedge clk);
            dp = (s == SYM_K);
            dm = (s == SYM_J);
            repeat (cpb - 1) @(negedge clk);
        end
    endtask

    task automatic drain_check();
        repeat (60) @(negedge clk);
        checks++;
        if (exp_wr.size() + exp_len.size() + exp_serr + exp_oerr != 0)
            fail({tag, " pending events"},
                 exp_wr.size() + exp_len.size() + exp_serr + exp_oerr, 0);
    endtask

    // event monitor, compared against the model queues on every clock
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (wr_en) begin
                int got;
                got = int'(wr_addr) * 256 + int'(wr_data);
                checks++;
                if (exp_wr.size() == 0) fail({tag, " unexpected write"}, got, -1);
                else begin
                    int e;
                    e = exp_wr.pop_front();
                    if (got != e) fail({tag, " write addr*256+data"}, got, e);
                end
            end
            if (pkt_done) begin
                checks++;
                if (exp_len.size() == 0) fail({tag, " unexpected done"}, int'(pkt_len), -1);
                else begin
                    int e;
                    e = exp_len.pop_front();
                    if (int'(pkt_len) != e) fail({tag, " packet length"}, int'(pkt_len), e);
                end
            end
            if (sync_err) begin
                checks++;
                if (exp_serr == 0) fail({tag, " unexpected sync_err"}, 1, 0);
                else exp_serr--;
            end
            if (ovf_err) begin
                checks++;
                if (exp_oerr == 0) fail({tag, " unexpected ovf_err"}, 1, 0);
                else exp_oerr--;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fail("watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++; if (wr_en !== 1'b0) fail("R1 wr_en", int'(wr_en), 0);
        checks++; if (pkt_done !== 1'b0) fail("R1 pkt_done", int'(pkt_done), 0);
        checks++; if ((sync_err | ovf_err) !== 1'b0) fail("R1 errors", int'(sync_err | ovf_err), 0);
        checks++; if (pkt_len !== '0) fail("R1 pkt_len", int'(pkt_len), 0);
        mon_on = 1;

        // R2 R3 R4: basic packet
        tag = "R2 R3 R4";
        add_idle(3); add_sync(); add_byte(8'hA5); add_byte(8'h3C); add_eop();
        expect_pkt(2, 8'hA5, 8'h3C, 0);
        play(CPB); drain_check();

        // R5: stuffed bits inside bytes
        tag = "R5";
        add_idle(3); add_sync(); add_byte(8'hFF); add_byte(8'hFF); add_byte(8'h01); add_eop();
        expect_pkt(3, 8'hFF, 8'hFF, 8'h01);
        play(CPB); drain_check();

        // R6: SE0 in mid-byte drops the partial byte
        tag = "R6";
        add_idle(3); add_sync(); add_byte(8'h12); add_bit(1); add_bit(0); add_bit(1); add_eop();
        expect_pkt(1, 8'h12, 0, 0);
        play(CPB); drain_check();

        // R7: one trailing dribble bit before SE0
        tag = "R7";
        add_idle(3); add_sync(); add_byte(8'h42); put_sym(lvl); add_eop();
        expect_pkt(1, 8'h42, 0, 0);
        play(CPB); drain_check();

        // R8: SE0 where a stuffed bit is due
        tag = "R8";
        add_idle(3); add_sync(); no_stuff = 1; add_byte(8'hFC); no_stuff = 0; add_eop();
        expect_pkt(1, 8'hFC, 0, 0);
        play(CPB); drain_check();

        // R9: overflow, then recovery
        tag = "R9";
        add_idle(3); add_sync();
        add_byte(8'h11); add_byte(8'h22); add_byte(8'h33); add_byte(8'h44); add_byte(8'h55);
        add_eop();
        for (int i = 0; i < 4; i++) exp_wr.push_back(i * 256 + 17 * (i + 1));
        exp_oerr = 1;
        play(CPB); drain_check();
        tag = "R9 recovery";
        add_idle(3); add_sync(); add_byte(8'h66); add_eop();
        expect_pkt(1, 8'h66, 0, 0);
        play(CPB); drain_check();

        // R10: start pattern that never completes
        tag = "R10";
        add_idle(3); put_sym(SYM_K); add_idle(6);
        exp_serr = 1;
        play(CPB); drain_check();

        // R11: slow bit periods, decoded through realignment
        tag = "R11";
        add_idle(3); add_sync(); add_byte(8'h00); add_byte(8'h55); add_byte(8'hAA); add_eop();
        expect_pkt(3, 8'h00, 8'h55, 8'hAA);
        play(CPB + 1); drain_check();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule